// File: doc/BRIEF.md
# Banked System Control Register

This block holds the processor's top-level system control word. It keeps a Secure and a Non-secure copy, and the current security state selects which copy is used. Software reaches the word through a coprocessor-style access port. The port carries four select fields, a direction bit, write data, the security state and the privilege level. The block answers with registered read data and a one-cycle undefined-instruction flag.

The copy for the current security state drives a set of control outputs into the rest of the core. These cover the MMU, alignment checking, the caches, branch prediction, swap instructions, the execute-never policies, exception endianness, exception state and the exception vector base.

Reserved bits are fixed to one or to zero. Three implemented bits take their reset value from configuration pins. A lock input stops Secure software from changing the Secure copy.

Top module: `sysctl_top`

## Requirements
- R1: Only an access with `accValid` high and select fields opc1=0, crn=1, crm=0, opc2=0 reads or writes the word. Any other field value changes no state and leaves `undefInstr` low.
- R2: `secState`=1 selects the Secure copy and `secState`=0 selects the Non-secure copy. This holds for reads, for writes and for the control outputs. A write to one copy leaves the other copy unchanged.
- R3: While `rstN` is low, both copies load bit 30 from `cfgExcState`, bit 25 from `cfgBigEnd` and bit 13 from `cfgHighVec`. All other implemented bits load 0. The load is synchronous.
- R4: An access at `privLevel`=0 raises `undefInstr` and changes no state. Any `privLevel` from 1 to 3 is allowed.
- R5: A write with `secState`=1 while `secWrLock`=1 raises `undefInstr` and leaves the Secure copy unchanged. Secure reads and Non-secure writes still work while the lock is high.
- R6: Bits 23, 22, 18, 16 and 6..3 always read as 1. Bits 31, 27, 26, 24, 21, 17, 15, 14 and 9..7 always read as 0. Writes to these bits are ignored.
- R7: While `longDescFmt`=1, read bits 29 and 28 return 1, and `accessFlagEn` and `remapEn` are low. The stored values of these bits are kept and come back once `longDescFmt` returns to 0.
- R8: Each control output follows one bit of the active copy:
  - `mmuEn` bit 0, `alignChk` bit 1, `dCacheEn` bit 2
  - `swapEn` bit 10, `branchPredEn` bit 11, `iCacheEn` bit 12
  - `wxn` bit 19, `uwxn` bit 20
  - `excBigEnd` bit 25, `remapEn` bit 28, `accessFlagEn` bit 29, `excState` bit 30
- R9: `vecBase` is 0xFFFF0000 when bit 13 of the active copy is 1. Otherwise it equals `vecBaseRemap`.
- R10: `rdData` and `undefInstr` update on the clock edge that takes the access. `undefInstr` stays high for exactly one cycle. Control outputs change on the edge that takes a write, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| accValid | input | 1 | Access request this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accOpc1 | input | 3 | First opcode select field |
| accCrn | input | 4 | Primary register select |
| accCrm | input | 4 | Secondary register select |
| accOpc2 | input | 3 | Second opcode select field |
| accWdata | input | 32 | Write data |
| secState | input | 1 | 1 = Secure, 0 = Non-secure |
| privLevel | input | 2 | Current privilege level |
| secWrLock | input | 1 | Blocks writes to the Secure copy |
| longDescFmt | input | 1 | Long-descriptor translation format in use |
| cfgExcState | input | 1 | Reset value of bit 30 |
| cfgBigEnd | input | 1 | Reset value of bit 25 |
| cfgHighVec | input | 1 | Reset value of bit 13 |
| vecBaseRemap | input | 32 | Vector base used when low vectors are selected |
| rdData | output | 32 | Registered read data |
| undefInstr | output | 1 | Undefined-instruction pulse |
| mmuEn | output | 1 | MMU enable |
| alignChk | output | 1 | Alignment check enable |
| dCacheEn | output | 1 | Data cache enable |
| iCacheEn | output | 1 | Instruction cache enable |
| branchPredEn | output | 1 | Branch prediction enable |
| swapEn | output | 1 | Swap instruction enable |
| wxn | output | 1 | Write implies execute-never |
| uwxn | output | 1 | Unprivileged write implies execute-never |
| accessFlagEn | output | 1 | Access flag enable |
| remapEn | output | 1 | Attribute remap enable |
| excBigEnd | output | 1 | Exception endianness |
| excState | output | 1 | Exception state select |
| vecBase | output | 32 | Exception vector base |

## Verification
Two rejection causes can hit the same access. A write at privilege level 0 can arrive while the Secure lock is high. The bench provokes this and expects exactly one `undefInstr` pulse and an unchanged Secure copy on a later read.

The long-descriptor override can also be active during the same cycle as a write to bits 29..28. The bench sets both bits with the override high and checks two things. While the override is high, `accessFlagEn` and `remapEn` stay low. Once it drops, both outputs return to 1 with no further write.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned WORD_W = 32;

  // implemented control bits
  localparam logic [WORD_W-1:0] IMPL_MASK = 32'h7218_3C07;
  // reserved bits that read as one
  localparam logic [WORD_W-1:0] RAO_MASK  = 32'h00C5_0078;
  // bits forced to one under the long-descriptor format
  localparam logic [WORD_W-1:0] LDF_MASK  = 32'h3000_0000;

  localparam int unsigned B_MMU    = 0;
  localparam int unsigned B_ALIGN  = 1;
  localparam int unsigned B_DCACHE = 2;
  localparam int unsigned B_SWAP   = 10;
  localparam int unsigned B_BRPRED = 11;
  localparam int unsigned B_ICACHE = 12;
  localparam int unsigned B_HIVEC  = 13;
  localparam int unsigned B_WXN    = 19;
  localparam int unsigned B_UWXN   = 20;
  localparam int unsigned B_BIGEND = 25;
  localparam int unsigned B_REMAP  = 28;
  localparam int unsigned B_AFLAG  = 29;
  localparam int unsigned B_EXCST  = 30;

  typedef struct packed {
    logic wrEn;
    logic wrSecure;
    logic rdEn;
    logic rdSecure;
    logic undef;
  } ctrlStrobe_t;

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter logic [2:0] SEL_OPC1 = 3'd0,
  parameter logic [3:0] SEL_CRN  = 4'd1,
  parameter logic [3:0] SEL_CRM  = 4'd0,
  parameter logic [2:0] SEL_OPC2 = 3'd0,
  parameter int unsigned PRIV_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [2:0]        accOpc1,
  input  logic [3:0]        accCrn,
  input  logic [3:0]        accCrm,
  input  logic [2:0]        accOpc2,
  input  logic              secState,
  input  logic [PRIV_W-1:0] privLevel,
  input  logic              secWrLock,
  output ctrlStrobe_t       strb,
  output logic              undefInstr
);

  logic selHit;
  logic privOk;
  logic lockHit;
  logic reject;

  assign selHit  = accValid && (accOpc1 == SEL_OPC1) && (accCrn == SEL_CRN)
                   && (accCrm == SEL_CRM) && (accOpc2 == SEL_OPC2);
  assign privOk  = (privLevel != '0);
  assign lockHit = accWrite && secState && secWrLock;
  assign reject  = selHit && (!privOk || lockHit);

  always_comb begin
    strb          = '0;
    strb.undef    = reject;
    strb.wrEn     = selHit && accWrite && !reject;
    strb.rdEn     = selHit && !accWrite && !reject;
    strb.wrSecure = secState;
    strb.rdSecure = secState;
  end

  always_ff @(posedge clk) begin
    if (!rstN) undefInstr <= 1'b0;
    else       undefInstr <= strb.undef;
  end

  // R4: level-0 access to this register is refused
  a_r4_pl0_undef : assert property (@(posedge clk) disable iff (!rstN)
    (selHit && privLevel == '0) |=> undefInstr);

  // R5: locked Secure write is refused
  a_r5_lock_undef : assert property (@(posedge clk) disable iff (!rstN)
    (selHit && accWrite && secState && secWrLock) |=> undefInstr);

  // R10: the flag is a single-cycle pulse tied to an access
  a_r10_undef_pulse : assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !undefInstr);

  // R1: a non-matching select never produces the flag
  a_r1_miss_quiet : assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !selHit) |=> !undefInstr);

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int unsigned     DATA_W    = WORD_W,
  parameter int unsigned     NUM_COPY  = 2,
  parameter logic [DATA_W-1:0] HIGH_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [DATA_W-1:0] accWdata,
  input  logic              secState,
  input  logic              longDescFmt,
  input  logic              cfgExcState,
  input  logic              cfgBigEnd,
  input  logic              cfgHighVec,
  input  logic [DATA_W-1:0] vecBaseRemap,
  output logic [DATA_W-1:0] rdData,
  output logic              mmuEn,
  output logic              alignChk,
  output logic              dCacheEn,
  output logic              iCacheEn,
  output logic              branchPredEn,
  output logic              swapEn,
  output logic              wxn,
  output logic              uwxn,
  output logic              accessFlagEn,
  output logic              remapEn,
  output logic              excBigEnd,
  output logic              excState,
  output logic [DATA_W-1:0] vecBase
);

  localparam logic [DATA_W-1:0] IMPL = DATA_W'(IMPL_MASK);
  localparam logic [DATA_W-1:0] RAO  = DATA_W'(RAO_MASK);
  localparam logic [DATA_W-1:0] LDF  = DATA_W'(LDF_MASK);
  localparam logic [DATA_W-1:0] RAZ  = ~(IMPL | RAO);

  logic [DATA_W-1:0] resetWord;
  logic [DATA_W-1:0] bankQ [NUM_COPY];
  logic [DATA_W-1:0] activeQ;
  logic [DATA_W-1:0] readSel;
  logic [DATA_W-1:0] readView;

  always_comb begin
    resetWord           = '0;
    resetWord[B_EXCST]  = cfgExcState;
    resetWord[B_BIGEND] = cfgBigEnd;
    resetWord[B_HIVEC]  = cfgHighVec;
  end

  // copy index 1 is Secure, index 0 is Non-secure
  for (genvar g = 0; g < NUM_COPY; g++) begin : gCopy
    logic [DATA_W-1:0] q;
    logic isSecure;
    assign isSecure = (g == 1);
    always_ff @(posedge clk) begin
      if (!rstN)
        q <= resetWord;
      else if (strb.wrEn && (strb.wrSecure == isSecure))
        q <= accWdata & IMPL;
    end
    assign bankQ[g] = q;
  end

  assign activeQ  = bankQ[secState];
  assign readSel  = bankQ[strb.rdSecure];
  assign readView = (readSel & IMPL) | RAO | (longDescFmt ? LDF : '0);

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= readView;
  end

  assign mmuEn        = activeQ[B_MMU];
  assign alignChk     = activeQ[B_ALIGN];
  assign dCacheEn     = activeQ[B_DCACHE];
  assign iCacheEn     = activeQ[B_ICACHE];
  assign branchPredEn = activeQ[B_BRPRED];
  assign swapEn       = activeQ[B_SWAP];
  assign wxn          = activeQ[B_WXN];
  assign uwxn         = activeQ[B_UWXN];
  assign accessFlagEn = activeQ[B_AFLAG] && !longDescFmt;
  assign remapEn      = activeQ[B_REMAP] && !longDescFmt;
  assign excBigEnd    = activeQ[B_BIGEND];
  assign excState     = activeQ[B_EXCST];
  assign vecBase      = activeQ[B_HIVEC] ? HIGH_BASE : vecBaseRemap;

  // R6: reserved bits come back fixed
  a_r6_reserved_read : assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> (((rdData & RAO) == RAO) && ((rdData & RAZ) == '0)));

  // R4, R5: a refused access leaves both copies untouched
  a_r4_refused_hold : assert property (@(posedge clk) disable iff (!rstN)
    strb.undef |=> ($stable(bankQ[0]) && $stable(bankQ[1])));

  // R2: a Non-secure write never touches the Secure copy
  a_r2_bank_isolate : assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !strb.wrSecure) |=> $stable(bankQ[1]));

  // R7: long-descriptor reads return ones in the two overridden bits
  a_r7_ldf_read : assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && longDescFmt) |=> (rdData[B_AFLAG:B_REMAP] == 2'b11));

endmodule

// File: rtl/sysctl_top.sv
module sysctl_top
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [2:0]        accOpc1,
  input  logic [3:0]        accCrn,
  input  logic [3:0]        accCrm,
  input  logic [2:0]        accOpc2,
  input  logic [DATA_W-1:0] accWdata,
  input  logic              secState,
  input  logic [PRIV_W-1:0] privLevel,
  input  logic              secWrLock,
  input  logic              longDescFmt,
  input  logic              cfgExcState,
  input  logic              cfgBigEnd,
  input  logic              cfgHighVec,
  input  logic [DATA_W-1:0] vecBaseRemap,
  output logic [DATA_W-1:0] rdData,
  output logic              undefInstr,
  output logic              mmuEn,
  output logic              alignChk,
  output logic              dCacheEn,
  output logic              iCacheEn,
  output logic              branchPredEn,
  output logic              swapEn,
  output logic              wxn,
  output logic              uwxn,
  output logic              accessFlagEn,
  output logic              remapEn,
  output logic              excBigEnd,
  output logic              excState,
  output logic [DATA_W-1:0] vecBase
);

  ctrlStrobe_t strb;

  sysctl_ctrl #(.PRIV_W(PRIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accOpc1(accOpc1), .accCrn(accCrn), .accCrm(accCrm), .accOpc2(accOpc2),
    .secState(secState), .privLevel(privLevel), .secWrLock(secWrLock),
    .strb(strb), .undefInstr(undefInstr)
  );

  sysctl_bank #(.DATA_W(DATA_W)) uBank (
    .clk(clk), .rstN(rstN), .strb(strb), .accWdata(accWdata),
    .secState(secState), .longDescFmt(longDescFmt),
    .cfgExcState(cfgExcState), .cfgBigEnd(cfgBigEnd), .cfgHighVec(cfgHighVec),
    .vecBaseRemap(vecBaseRemap), .rdData(rdData),
    .mmuEn(mmuEn), .alignChk(alignChk), .dCacheEn(dCacheEn), .iCacheEn(iCacheEn),
    .branchPredEn(branchPredEn), .swapEn(swapEn), .wxn(wxn), .uwxn(uwxn),
    .accessFlagEn(accessFlagEn), .remapEn(remapEn), .excBigEnd(excBigEnd),
    .excState(excState), .vecBase(vecBase)
  );

endmodule

// File: tb/tb_sysctl_top.sv
module tb_sysctl_top;

  localparam int CLK_P = 10;
  localparam int NVEC  = 14;

  logic        clk = 1'b0;
  logic        rstN;
  logic        accValid, accWrite;
  logic [2:0]  accOpc1, accOpc2;
  logic [3:0]  accCrn, accCrm;
  logic [31:0] accWdata;
  logic        secState;
  logic [1:0]  privLevel;
  logic        secWrLock, longDescFmt;
  logic        cfgExcState, cfgBigEnd, cfgHighVec;
  logic [31:0] vecBaseRemap;
  logic [31:0] rdData, vecBase;
  logic        undefInstr, mmuEn, alignChk, dCacheEn, iCacheEn, branchPredEn;
  logic        swapEn, wxn, uwxn, accessFlagEn, remapEn, excBigEnd, excState;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  sysctl_top dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accOpc1(accOpc1), .accCrn(accCrn), .accCrm(accCrm), .accOpc2(accOpc2),
    .accWdata(accWdata), .secState(secState), .privLevel(privLevel),
    .secWrLock(secWrLock), .longDescFmt(longDescFmt),
    .cfgExcState(cfgExcState), .cfgBigEnd(cfgBigEnd), .cfgHighVec(cfgHighVec),
    .vecBaseRemap(vecBaseRemap), .rdData(rdData), .undefInstr(undefInstr),
    .mmuEn(mmuEn), .alignChk(alignChk), .dCacheEn(dCacheEn), .iCacheEn(iCacheEn),
    .branchPredEn(branchPredEn), .swapEn(swapEn), .wxn(wxn), .uwxn(uwxn),
    .accessFlagEn(accessFlagEn), .remapEn(remapEn), .excBigEnd(excBigEnd),
    .excState(excState), .vecBase(vecBase)
  );

  // {chkRd, write, sec, priv[1:0], lock, ldf, wdata[31:0], expUndef, expRd[31:0]}
  localparam logic [71:0] VEC [NVEC] = '{
    {1'b1,1'b0,1'b0,2'd1,1'b0,1'b0,32'h0000_0000,1'b0,32'h40C5_2078}, // R3 NS reset
    {1'b0,1'b1,1'b0,2'd1,1'b0,1'b0,32'hFFFF_FFFF,1'b0,32'h0},         // NS write all
    {1'b1,1'b0,1'b0,2'd1,1'b0,1'b0,32'h0000_0000,1'b0,32'h72DD_3C7F}, // R6 masks
    {1'b1,1'b0,1'b1,2'd1,1'b0,1'b0,32'h0000_0000,1'b0,32'h40C5_2078}, // R2 S untouched
    {1'b0,1'b1,1'b1,2'd2,1'b0,1'b0,32'h0000_0005,1'b0,32'h0},         // S write
    {1'b1,1'b0,1'b1,2'd1,1'b0,1'b0,32'h0000_0000,1'b0,32'h00C5_007D}, // R2 S readback
    {1'b0,1'b1,1'b1,2'd1,1'b1,1'b0,32'hFFFF_FFFF,1'b1,32'h0},         // R5 locked write
    {1'b1,1'b0,1'b1,2'd1,1'b1,1'b0,32'h0000_0000,1'b0,32'h00C5_007D}, // R5 read allowed
    {1'b0,1'b1,1'b0,2'd1,1'b1,1'b0,32'h0000_0001,1'b0,32'h0},         // R5 NS write ok
    {1'b1,1'b0,1'b0,2'd3,1'b0,1'b0,32'h0000_0000,1'b0,32'h00C5_0079}, // R5 NS readback
    {1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,32'hFFFF_FFFF,1'b1,32'h0},         // R4 PL0 write
    {1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,32'h0000_0000,1'b1,32'h0},         // R4 PL0 read
    {1'b1,1'b0,1'b0,2'd1,1'b0,1'b0,32'h0000_0000,1'b0,32'h00C5_0079}, // R4 unchanged
    {1'b1,1'b0,1'b0,2'd1,1'b0,1'b1,32'h0000_0000,1'b0,32'h30C5_0079}  // R7 forced ones
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one access: drive after a falling edge, taken at the rising edge,
  // results sampled at the next falling edge
  task automatic access(input logic wr, input logic sec, input logic [1:0] pl,
                        input logic lk, input logic ldf, input logic [31:0] wd);
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; secState = sec; privLevel = pl;
    secWrLock = lk; longDescFmt = ldf; accWdata = wd;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0; secWrLock = 1'b0;
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; accValid = 1'b0; accWrite = 1'b0;
    accOpc1 = 3'd0; accCrn = 4'd1; accCrm = 4'd0; accOpc2 = 3'd0;
    accWdata = '0; secState = 1'b0; privLevel = 2'd1; secWrLock = 1'b0;
    longDescFmt = 1'b0; cfgExcState = 1'b1; cfgBigEnd = 1'b0; cfgHighVec = 1'b1;
    vecBaseRemap = 32'h0000_1000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R3 / R8 / R9 reset state seen on the control outputs
    chk("R3 excState", {31'd0, excState}, 32'd1);
    chk("R3 excBigEnd", {31'd0, excBigEnd}, 32'd0);
    chk("R3 mmuEn", {31'd0, mmuEn}, 32'd0);
    chk("R9 high vectors", vecBase, 32'hFFFF_0000);
    chk("R10 undef idle", {31'd0, undefInstr}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [71:0] v;
      v = VEC[i];
      access(v[70], v[69], v[68:67], v[66], v[65], v[64:33]);
      chk($sformatf("R10 vec%0d undef", i), {31'd0, undefInstr}, {31'd0, v[32]});
      if (v[71]) chk($sformatf("R6 vec%0d read", i), rdData, v[31:0]);
    end
    longDescFmt = 1'b0;

    // R1: wrong select field changes nothing
    accOpc2 = 3'd1;
    access(1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 32'hFFFF_FFFF);
    chk("R1 miss no undef", {31'd0, undefInstr}, 32'd0);
    accOpc2 = 3'd0;
    access(1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0);
    chk("R1 miss no write", rdData, 32'h00C5_0079);

    // R2 / R8 / R9: outputs follow the copy for the current state
    secState = 1'b0; #1;
    chk("R8 NS mmuEn", {31'd0, mmuEn}, 32'd1);
    chk("R2 NS dCacheEn", {31'd0, dCacheEn}, 32'd0);
    secState = 1'b1; #1;
    chk("R2 S dCacheEn", {31'd0, dCacheEn}, 32'd1);
    chk("R9 low vectors remap", vecBase, 32'h0000_1000);
    chk("R8 S excState", {31'd0, excState}, 32'd0);

    // R10: outputs change only at the edge that takes the write
    @(negedge clk);
    accValid = 1'b1; accWrite = 1'b1; secState = 1'b0; privLevel = 2'd1;
    accWdata = 32'h0218_3C03;
    #1;
    chk("R10 before edge", {31'd0, alignChk}, 32'd0);
    @(posedge clk); #1;
    accValid = 1'b0; accWrite = 1'b0;
    chk("R10 after edge", {31'd0, alignChk}, 32'd1);
    chk("R8 iCacheEn", {31'd0, iCacheEn}, 32'd1);
    chk("R8 brpred swap", {30'd0, branchPredEn, swapEn}, 32'd3);
    chk("R8 wxn uwxn", {30'd0, wxn, uwxn}, 32'd3);
    chk("R8 excBigEnd", {31'd0, excBigEnd}, 32'd1);

    // R7: write the two overridden bits while the format input is high
    access(1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 32'h3000_0003);
    chk("R7 outputs masked", {30'd0, accessFlagEn, remapEn}, 32'd0);
    longDescFmt = 1'b0; #1;
    chk("R7 stored value kept", {30'd0, accessFlagEn, remapEn}, 32'd3);

    // R4 + R5 together: PL0 write to Secure copy under the lock
    access(1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    chk("R4 R5 combined undef", {31'd0, undefInstr}, 32'd1);
    @(negedge clk);
    chk("R10 undef one cycle", {31'd0, undefInstr}, 32'd0);
    access(1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 32'h0);
    chk("R5 Secure copy intact", rdData, 32'h00C5_007D);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule